// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Status Unit

This block gathers completion and error events from up to sixteen DMA channels and keeps each one as a sticky flag. Each channel has its own interrupt line. The line is raised while the channel's enable bit is set and either of its flags is set. When a channel errors, the block also records the cause, so software can tell a bus error from a termination error. Next to this status the block holds a freeze control and a one-cycle reset control for each channel, plus two global burst-enable bits.

Software reaches four registers over a simple single-cycle register bus. Every register has three write aliases:
- a replace alias, which loads the written word;
- a set alias, which ORs the written ones in;
- a clear alias, which removes the written ones.

Because of the aliases, software can acknowledge or enable one channel without a read-modify-write, and without racing the hardware events. Reads are combinational from the address. Every alias of a register reads back the same value.

Top module: `dma_irq_status_unit`

## Requirements
- R1: After reset, all four registers read 0 and all outputs (`irq_o`, `freeze_o`, `ch_rst_o`, `burst_en_o`) are 0.
- R2: A pulse on `done_evt_i[n]` sets bit n of the interrupt register (register index 1). The bit stays set until software writes it to 0.
- R3: Bits [31:16] of the interrupt register are enables, with bit 16+n belonging to channel n. `irq_o[n]` is 1 exactly while enable n is set and either completion bit n or error bit n is set.
- R4: A pulse on `err_evt_i[n]` sets bit n of the error register (register index 2). In the same cycle, bit 16+n is loaded with `err_bus_i[n]`: 1 for a bus error, 0 for a termination error. A later error event overwrites that cause bit.
- R5: The register index is `addr_i[6:4]`: 0 is global control, 1 is interrupt, 2 is error, 3 is channel control. The write alias is `addr_i[3:2]`: 0 replaces the register, 1 ORs the data in, 2 clears the bits written as 1, and 3 has no effect. A read returns the register at any alias. Indices 4 to 7 read 0 and ignore writes.
- R6: A completion or error event in the same cycle as a write that clears that bit leaves the bit set.
- R7: Bits [15:0] of the channel-control register are freeze bits, and `freeze_o[n]` follows bit n.
- R8: Writing 1 to channel-control bit 16+n through alias 0 or 1 makes `ch_rst_o[n]` high for exactly the next cycle. The bit reads 1 during that cycle and 0 afterwards. A write through alias 2 produces no pulse.
- R9: In the global-control register only bits 28 and 29 are stored, and they drive `burst_en_o[0]` and `burst_en_o[1]`. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 8 | Byte address: register index and alias |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| done_evt_i | input | 16 | Completion event pulse for each channel |
| err_evt_i | input | 16 | Error event pulse for each channel |
| err_bus_i | input | 16 | Error cause for each channel: 1 bus error, 0 termination |
| irq_o | output | 16 | Interrupt line for each channel |
| freeze_o | output | 16 | Freeze control for each channel |
| ch_rst_o | output | 16 | One-cycle reset pulse for each channel |
| burst_en_o | output | 2 | Global burst enables |

## Verification
The hardest situation to reach is an event on a channel landing in exactly the same cycle as a clear-alias write to that channel's bit. A loose ordering would let the event be lost. The bench drives the event pulse and the write strobe from the same falling edge, so both are sampled at one rising edge. It then reads the register back, expecting only the colliding bit to survive among the bits that were cleared. The one-cycle reset pulse is checked on two consecutive falling edges, so a pulse one cycle too long is caught.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned HALF = 16;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_NOP = 2'd3
  } alias_op_e;

  localparam int unsigned IDX_GLOB = 0;
  localparam int unsigned IDX_IRQ  = 1;
  localparam int unsigned IDX_ERR  = 2;
  localparam int unsigned IDX_CHC  = 3;
  localparam int unsigned NUM_REG  = 4;

  function automatic logic [DW-1:0] apply_alias(logic [DW-1:0] cur,
                                                logic [DW-1:0] wd,
                                                alias_op_e     op);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REG-1:0] wr_sel_o,
  output logic [NUM_REG-1:0] rd_sel_o,
  output alias_op_e         op_o
);
  logic [2:0] idx;
  assign idx  = addr_i[6:4];
  assign op_o = alias_op_e'(addr_i[3:2]);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_sel
    assign rd_sel_o[r] = (idx == 3'(r));
    assign wr_sel_o[r] = rd_sel_o[r] && wr_i && (op_o != OP_NOP);
  end
endmodule

// File: rtl/dma_irq_chan_cell.sv
module dma_irq_chan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_evt_i,
  input  logic err_evt_i,
  input  logic err_bus_i,
  input  logic irq_wr_i,
  input  logic done_v_i,
  input  logic en_v_i,
  input  logic err_wr_i,
  input  logic errf_v_i,
  input  logic cause_v_i,
  input  logic chc_wr_i,
  input  logic frz_v_i,
  input  logic rst_req_i,
  output logic done_o,
  output logic en_o,
  output logic errf_o,
  output logic cause_o,
  output logic frz_o,
  output logic rst_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      en_o    <= 1'b0;
      errf_o  <= 1'b0;
      cause_o <= 1'b0;
      frz_o   <= 1'b0;
      rst_o   <= 1'b0;
    end else begin
      // events OR in after the bus update so they win over a clear
      done_o <= (irq_wr_i ? done_v_i : done_o) | done_evt_i;
      errf_o <= (err_wr_i ? errf_v_i : errf_o) | err_evt_i;
      if (irq_wr_i) en_o <= en_v_i;
      if (err_evt_i)     cause_o <= err_bus_i;
      else if (err_wr_i) cause_o <= cause_v_i;
      if (chc_wr_i) frz_o <= frz_v_i;
      rst_o <= rst_req_i;
    end
  end

  assign irq_o = en_o & (done_o | errf_o);

  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_i |=> done_o);

  // R4
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> (errf_o && cause_o == $past(err_bus_i)));

  // R8
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && !rst_req_i) |=> !rst_o);

  // R3
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_wr_i && !en_v_i) |=> !irq_o);
endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [NUM_CH-1:0] err_bus_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] freeze_o,
  output logic [NUM_CH-1:0] ch_rst_o,
  output logic [1:0]        burst_en_o
);
  localparam int unsigned BURST_LO = 28;

  logic [NUM_REG-1:0] wr_sel, rd_sel;
  alias_op_e          op;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wr_sel_o(wr_sel),
    .rd_sel_o(rd_sel),
    .op_o    (op)
  );

  logic [NUM_CH-1:0] done_q, en_q, errf_q, cause_q, frz_q, rstp_q;
  logic [1:0]        burst_q;
  logic [DW-1:0]     glob_w, irq_w, err_w, chc_w;
  logic [DW-1:0]     glob_n, irq_n, err_n, chc_n;

  always_comb begin
    glob_w = '0;
    glob_w[BURST_LO +: 2] = burst_q;
    irq_w = '0;
    err_w = '0;
    chc_w = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      irq_w[n]        = done_q[n];
      irq_w[HALF + n] = en_q[n];
      err_w[n]        = errf_q[n];
      err_w[HALF + n] = cause_q[n];
      chc_w[n]        = frz_q[n];
      chc_w[HALF + n] = rstp_q[n];
    end
  end

  assign glob_n = apply_alias(glob_w, wdata_i, op);
  assign irq_n  = apply_alias(irq_w,  wdata_i, op);
  assign err_n  = apply_alias(err_w,  wdata_i, op);
  assign chc_n  = apply_alias(chc_w,  wdata_i, op);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                burst_q <= '0;
    else if (wr_sel[IDX_GLOB])  burst_q <= glob_n[BURST_LO +: 2];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic rst_req;
    assign rst_req = wr_sel[IDX_CHC] && (op != OP_CLR) && wdata_i[HALF + n];

    dma_irq_chan_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .done_evt_i(done_evt_i[n]),
      .err_evt_i (err_evt_i[n]),
      .err_bus_i (err_bus_i[n]),
      .irq_wr_i  (wr_sel[IDX_IRQ]),
      .done_v_i  (irq_n[n]),
      .en_v_i    (irq_n[HALF + n]),
      .err_wr_i  (wr_sel[IDX_ERR]),
      .errf_v_i  (err_n[n]),
      .cause_v_i (err_n[HALF + n]),
      .chc_wr_i  (wr_sel[IDX_CHC]),
      .frz_v_i   (chc_n[n]),
      .rst_req_i (rst_req),
      .done_o    (done_q[n]),
      .en_o      (en_q[n]),
      .errf_o    (errf_q[n]),
      .cause_o   (cause_q[n]),
      .frz_o     (frz_q[n]),
      .rst_o     (rstp_q[n]),
      .irq_o     (irq_o[n])
    );
  end

  always_comb begin
    unique case (1'b1)
      rd_sel[IDX_GLOB]: rdata_o = glob_w;
      rd_sel[IDX_IRQ]:  rdata_o = irq_w;
      rd_sel[IDX_ERR]:  rdata_o = err_w;
      rd_sel[IDX_CHC]:  rdata_o = chc_w;
      default:          rdata_o = '0;
    endcase
  end

  assign freeze_o   = frz_q;
  assign ch_rst_o   = rstp_q;
  assign burst_en_o = burst_q;

  // R5
  nop_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[3:2] == 2'd3 && addr_i[6:4] == 3'd3) |=> $stable(freeze_o));

  // R8
  clr_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[6:4] == 3'd3 && addr_i[3:2] == 2'd2) |=> (ch_rst_o == '0));
endmodule

// File: tb/dma_irq_status_unit_test.sv
module dma_irq_status_unit_test;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  done_evt = '0, err_evt = '0, err_bus = '0;
  logic [NCH-1:0]  irq, frz, chrst;
  logic [1:0]      burst;
  int              errors = 0, checks = 0;
  bit              finished = 1'b0;

  always #2 clk = ~clk;

  dma_irq_status_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_evt_i(done_evt), .err_evt_i(err_evt),
    .err_bus_i(err_bus), .irq_o(irq), .freeze_o(frz), .ch_rst_o(chrst),
    .burst_en_o(burst)
  );

  function automatic logic [7:0] mk_addr(int idx, int op);
    return {1'b0, 3'(idx), 2'(op), 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int idx, int op, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = mk_addr(idx, op); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(int idx, int op, output logic [31:0] v);
    addr = mk_addr(idx, op);
    #0.5;
    v = rdata;
  endtask

  task automatic evt(logic [NCH-1:0] d, logic [NCH-1:0] e, logic [NCH-1:0] b);
    @(negedge clk);
    done_evt = d; err_evt = e; err_bus = b;
    @(negedge clk);
    done_evt = '0; err_evt = '0; err_bus = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int r = 0; r < 4; r++) begin rd(r, 0, v); chk("R1 reg", v, 0); end
    chk("R1 outs", {irq, frz, chrst, 14'd0, burst}, 0);

    // R2, R3 completion path per channel
    for (int n = 0; n < NCH; n++) begin
      evt(NCH'(1) << n, '0, '0);
      rd(1, 0, v); chk("R2 done flag", v, 32'(1) << n);
      chk("R3 masked", 32'(irq), 0);
      bus_wr(1, 1, 32'(1) << (16 + n));
      rd(1, 0, v); chk("R2 held", v, (32'(1) << n) | (32'(1) << (16 + n)));
      chk("R3 irq on", 32'(irq), 32'(1) << n);
      bus_wr(1, 2, 32'(1) << n);
      chk("R3 irq off", 32'(irq), 0);
      rd(1, 1, v); chk("R5 clear alias", v, 32'(1) << (16 + n));
      bus_wr(1, 0, 0);
    end

    // R4 error path with alternating cause
    for (int n = 0; n < NCH; n++) begin
      logic b;
      b = n[0];
      evt('0, NCH'(1) << n, b ? (NCH'(1) << n) : '0);
      rd(2, 0, v);
      chk("R4 err word", v, (32'(1) << n) | (b ? (32'(1) << (16 + n)) : 0));
      chk("R3 err masked", 32'(irq), 0);
      bus_wr(1, 0, 32'(1) << (16 + n));
      chk("R3 err irq", 32'(irq), 32'(1) << n);
      bus_wr(2, 2, 32'hFFFF_FFFF);
      rd(2, 0, v); chk("R4 cleared", v, 0);
      bus_wr(1, 0, 0);
    end
    evt('0, 16'h0008, 16'h0008);
    evt('0, 16'h0008, 16'h0000);
    rd(2, 0, v); chk("R4 cause overwrite", v, 32'h0000_0008);
    bus_wr(2, 0, 0);

    // R6 collisions with clear alias
    bus_wr(1, 0, 32'h0000_00FF);
    @(negedge clk);
    wr = 1'b1; addr = mk_addr(1, 2); wdata = 32'h0000_00FF; done_evt = 16'h0004;
    @(negedge clk);
    wr = 1'b0; done_evt = '0;
    rd(1, 0, v); chk("R6 done collision", v, 32'h0000_0004);
    bus_wr(2, 0, 32'h0000_0030);
    @(negedge clk);
    wr = 1'b1; addr = mk_addr(2, 2); wdata = 32'h0000_0030; err_evt = 16'h0010;
    err_bus = 16'h0010;
    @(negedge clk);
    wr = 1'b0; err_evt = '0; err_bus = '0;
    rd(2, 0, v); chk("R6 err collision", v, 32'h0010_0010);
    bus_wr(1, 0, 0); bus_wr(2, 0, 0);

    // R5, R7 aliases on freeze bits
    bus_wr(3, 0, 32'h0000_00A5); chk("R7 base", 32'(frz), 32'h00A5);
    bus_wr(3, 1, 32'h0000_0F00); chk("R7 set", 32'(frz), 32'h0FA5);
    bus_wr(3, 2, 32'h0000_00F0); chk("R7 clear", 32'(frz), 32'h0F05);
    bus_wr(3, 3, 32'hFFFF_FFFF); chk("R5 nop alias", 32'(frz), 32'h0F05);
    chk("R5 nop no pulse", 32'(chrst), 0);
    rd(3, 2, v); chk("R5 read any alias", v, 32'h0000_0F05);
    bus_wr(5, 0, 32'hFFFF_FFFF);
    rd(5, 0, v); chk("R5 unmapped", v, 0);
    rd(3, 0, v); chk("R5 unmapped no write", v, 32'h0000_0F05);

    // R8 reset pulses
    for (int n = 0; n < NCH; n++) begin
      bus_wr(3, n % 2, 32'(1) << (16 + n) | ((n % 2 == 0) ? 32'h0F05 : 0));
      chk("R8 pulse", 32'(chrst), 32'(1) << n);
      rd(3, 0, v); chk("R8 readback", v, (32'(1) << (16 + n)) | 32'h0F05);
      @(negedge clk);
      chk("R8 one cycle", 32'(chrst), 0);
      rd(3, 0, v); chk("R8 self clear", v, 32'h0000_0F05);
    end
    bus_wr(3, 2, 32'h0001_0000);
    chk("R8 clear alias", 32'(chrst), 0);

    // R9 global control
    bus_wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 0, v); chk("R9 stored bits", v, 32'h3000_0000);
    chk("R9 burst", 32'(burst), 3);
    bus_wr(0, 2, 32'h1000_0000);
    chk("R9 burst clr", 32'(burst), 2);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule